// File: doc/BRIEF.md
# FPGA Configuration Phase Controller

This block steps an attached programmable device through its configuration phases. Phase changes come from two sources: software writes to a control register, and sideband indications from neighbouring logic. One indication reports that the configuration bitstream has been accepted. The other reports that the trailing clock burst has finished. The bitstream data path, the pulse generator and the interrupt monitor sit outside this block. They take their settings from the block's field outputs.

Software uses a 32-bit register port with a one-cycle read latency. A status word reports the current phase code and the sampled mode-select pins. A control word holds these fields: enable, an active-low chip-enable, a configuration-reset pull, a clock ratio, a data-path enable and a bus width. A third word, placed at offset 0x850, mirrors the sampled done indication. Software drives a configuration by writing the control word in steps. After each step it polls the status word until the expected phase appears.

Top module: `cfg_phase_ctrl`

## Requirements
- R1: After reset the phase code is 0 (power-off), the control word reads 0, `cfg_rst_n_o` is 1 and `chip_en_n_o` is 0.
- R2: A read of offset 0x4 returns the control word one cycle after the request. Only these bits are writable: 0 (enable), 1 (active-low chip enable), 2 (reset pull), 7:6 (clock ratio), 8 (data-path enable) and 9 (bus width). All other bits read 0.
- R3: A read of offset 0x0 returns the phase code in bits 2:0 and the mode select in bits 7:3, sampled one cycle earlier. All other bits read 0.
- R4: While enable and reset pull are both set, the phase becomes reset (1) on the next cycle, from any phase.
- R5: In reset, with enable set and reset pull clear, the phase moves to configuration (2).
- R6: In configuration, a rising edge of `cfg_done_i` moves the phase to initialization (3). A level that was already high when configuration began does not.
- R7: In initialization, the phase moves to user (4) only in a cycle where data-path enable is clear, `cfg_done_i` is high and `burst_done_i` is high.
- R8: While enable is clear, the phase goes to power-off (0), except when it is user, which is held.
- R9: `cfg_rst_n_o` is low exactly when enable and reset pull are both set. `chip_en_n_o`, `clk_ratio_o`, `datapath_en_o` and `bus_wide_o` follow control bits 1, 7:6, 8 and 9.
- R10: A read of offset 0x850 returns the sampled `cfg_done_i` in bit 10 and 0 in every other bit.
- R11: Writes to any offset other than 0x4 change nothing. Reads of any offset other than 0x0, 0x4 and 0x850 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid one cycle after a read request, then held |
| mode_sel_i | input | 5 | Mode-select pins |
| cfg_done_i | input | 1 | Bitstream accepted |
| burst_done_i | input | 1 | Trailing clock burst finished |
| cfg_rst_n_o | output | 1 | Active-low configuration reset pin |
| chip_en_n_o | output | 1 | Active-low chip enable |
| clk_ratio_o | output | 2 | Clock ratio to the pulse generator |
| datapath_en_o | output | 1 | Data-path enable to the bitstream path |
| bus_wide_o | output | 1 | Bus width select to the bitstream path |

## Verification
The bench raises `cfg_done_i` during reset, so the level is already high when configuration begins. A design that detects levels instead of edges would jump straight to initialization. The bench then holds initialization with only some of the three exit conditions true. A design that ignored data-path enable or the burst handshake would reach user too early. The bench clears enable once from user and once from configuration. This separates the held case from the forced power-off case. It also writes all ones to the control word to expose reserved bits that can be stored.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  typedef enum logic [2:0] {
    PH_OFF  = 3'd0,
    PH_RST  = 3'd1,
    PH_CFG  = 3'd2,
    PH_INIT = 3'd3,
    PH_USER = 3'd4
  } phase_e;

  localparam int unsigned OFS_STAT  = 'h0;
  localparam int unsigned OFS_CTRL  = 'h4;
  localparam int unsigned OFS_XPORT = 'h850;

  localparam int unsigned STAT_MODE_LSB = 3;
  localparam int unsigned XPORT_DONE    = 10;
  localparam int unsigned CTRL_W        = 10;
  localparam logic [CTRL_W-1:0] CTRL_WMASK = 10'h3C7;

  typedef struct packed {
    logic       wide;
    logic       dp;
    logic [1:0] ratio;
    logic [2:0] rsv;
    logic       pull;
    logic       nce;
    logic       en;
  } ctrl_t;

endpackage

// File: rtl/cfgp_phase.sv
module cfgp_phase
  import cfgp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  ctrl_t  ctrl_i,
  input  logic   done_i,
  input  logic   burst_i,
  output phase_e phase_o,
  output logic   done_q_o
);

  phase_e ph_q, ph_d;
  logic   done_q;
  logic   done_rise;

  assign done_rise = done_i & ~done_q;

  always_comb begin
    ph_d = ph_q;
    if (!ctrl_i.en && ph_q != PH_USER) begin
      ph_d = PH_OFF;
    end else if (ctrl_i.en && ctrl_i.pull) begin
      ph_d = PH_RST;
    end else begin
      unique case (ph_q)
        PH_RST:  if (!ctrl_i.pull) ph_d = PH_CFG;
        PH_CFG:  if (done_rise) ph_d = PH_INIT;
        PH_INIT: if (!ctrl_i.dp && done_i && burst_i) ph_d = PH_USER;
        default: ph_d = ph_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_OFF;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      done_q <= done_i;
    end
  end

  assign phase_o  = ph_q;
  assign done_q_o = done_q;

endmodule

// File: rtl/cfgp_regs.sv
module cfgp_regs
  import cfgp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int MODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  phase_e            phase_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              done_q_i,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_XPORT = ADDR_W'(OFS_XPORT);

  ctrl_t             ctrl_q, ctrl_d;
  logic [MODE_W-1:0] mode_q;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              wr_ctrl, rd_en;

  assign wr_ctrl = sel_i & we_i & (addr_i == A_CTRL);
  assign rd_en   = sel_i & ~we_i;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = ctrl_t'(wdata_i[CTRL_W-1:0] & CTRL_WMASK);
  end

  always_comb begin
    rd_d = rd_q;
    if (rd_en) begin
      rd_d = '0;
      if (addr_i == A_STAT) begin
        rd_d[2:0]                   = phase_i;
        rd_d[STAT_MODE_LSB +: MODE_W] = mode_q;
      end else if (addr_i == A_CTRL) begin
        rd_d[CTRL_W-1:0] = ctrl_q;
      end else if (addr_i == A_XPORT) begin
        rd_d[XPORT_DONE] = done_q_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mode_q <= '0;
      rd_q   <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      mode_q <= mode_i;
      rd_q   <= rd_d;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign rdata_o = rd_q;

endmodule

// File: rtl/cfg_phase_ctrl.sv
module cfg_phase_ctrl
  import cfgp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int MODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [MODE_W-1:0] mode_sel_i,
  input  logic              cfg_done_i,
  input  logic              burst_done_i,
  output logic              cfg_rst_n_o,
  output logic              chip_en_n_o,
  output logic [1:0]        clk_ratio_o,
  output logic              datapath_en_o,
  output logic              bus_wide_o
);

  ctrl_t  ctrl_w;
  phase_e phase_w;
  logic   done_q_w;

  cfgp_regs #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .MODE_W(MODE_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_i   (bus_sel_i),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .phase_i (phase_w),
    .mode_i  (mode_sel_i),
    .done_q_i(done_q_w),
    .ctrl_o  (ctrl_w),
    .rdata_o (bus_rdata_o)
  );

  cfgp_phase u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_i  (ctrl_w),
    .done_i  (cfg_done_i),
    .burst_i (burst_done_i),
    .phase_o (phase_w),
    .done_q_o(done_q_w)
  );

  assign cfg_rst_n_o   = ~(ctrl_w.en & ctrl_w.pull);
  assign chip_en_n_o   = ctrl_w.nce;
  assign clk_ratio_o   = ctrl_w.ratio;
  assign datapath_en_o = ctrl_w.dp;
  assign bus_wide_o    = ctrl_w.wide;

endmodule

// File: rtl/cfg_phase_ctrl_chk.sv
module cfg_phase_ctrl_chk
  import cfgp_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input phase_e phase,
  input ctrl_t  ctrl,
  input logic   cfg_done_i,
  input logic   burst_done_i,
  input logic   cfg_rst_n_o
);

  a_r3_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    phase inside {PH_OFF, PH_RST, PH_CFG, PH_INIT, PH_USER});

  a_r4_pull_to_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.en && ctrl.pull) |=> phase == PH_RST);

  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RST && ctrl.en && !ctrl.pull) |=> phase == PH_CFG);

  a_r6_init_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_INIT && $past(phase) != PH_INIT) |-> $past(phase) == PH_CFG);

  a_r7_user_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_USER && $past(phase) != PH_USER) |->
      ($past(phase) == PH_INIT && $past(burst_done_i) && $past(cfg_done_i)));

  a_r8_power_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.en && phase != PH_USER) |=> phase == PH_OFF);

  a_r9_pin_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rst_n_o |=> phase == PH_RST);

endmodule

bind cfg_phase_ctrl cfg_phase_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .phase       (phase_w),
  .ctrl        (ctrl_w),
  .cfg_done_i  (cfg_done_i),
  .burst_done_i(burst_done_i),
  .cfg_rst_n_o (cfg_rst_n_o)
);

// File: tb/cfg_phase_ctrl_test.sv
`timescale 1ns/1ps
module cfg_phase_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [4:0]  mode = 5'h0A;
  logic        cdone = 1'b0, bdone = 1'b0;
  logic        rstpin, cen_n, dpen, wide;
  logic [1:0]  ratio;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cfg_phase_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .mode_sel_i(mode), .cfg_done_i(cdone), .burst_done_i(bdone),
    .cfg_rst_n_o(rstpin), .chip_en_n_o(cen_n), .clk_ratio_o(ratio),
    .datapath_en_o(dpen), .bus_wide_o(wide)
  );

  // behavioural reference model
  int          m_phase, m_done, m_mode;
  logic [31:0] m_ctrl, m_rdata;

  always @(posedge clk or negedge rst_n) begin
    int np;
    if (!rst_n) begin
      m_phase = 0; m_done = 0; m_mode = 0; m_ctrl = 0; m_rdata = 0;
    end else begin
      np = m_phase;
      if (!m_ctrl[0] && m_phase != 4) np = 0;
      else if (m_ctrl[0] && m_ctrl[2]) np = 1;
      else if (m_phase == 1 && !m_ctrl[2]) np = 2;
      else if (m_phase == 2 && cdone && m_done == 0) np = 3;
      else if (m_phase == 3 && !m_ctrl[8] && cdone && bdone) np = 4;
      if (sel && !we) begin
        if (addr == 12'h0) m_rdata = (m_mode << 3) | m_phase;
        else if (addr == 12'h4) m_rdata = m_ctrl;
        else if (addr == 12'h850) m_rdata = m_done << 10;
        else m_rdata = 0;
      end
      if (sel && we && addr == 12'h4) m_ctrl = wdata & 32'h3C7;
      m_phase = np;
      m_done = cdone;
      m_mode = mode;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2 rdata model", rdata, m_rdata);
      chk("R9 cfg_rst_n_o model", {31'b0, rstpin}, {31'b0, ~(m_ctrl[0] & m_ctrl[2])});
      chk("R9 chip_en_n_o model", {31'b0, cen_n}, {31'b0, m_ctrl[1]});
      chk("R9 ratio/dp/wide model", {28'b0, ratio, dpen, wide},
          {28'b0, m_ctrl[7:6], m_ctrl[8], m_ctrl[9]});
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; we = 0;
    idle(2);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    sel = 1; we = 0; addr = a;
    @(negedge clk);
    sel = 0;
    chk(tag, rdata, exp);
  endtask

  function automatic logic [31:0] st(input int ph);
    return (32'(mode) << 3) | 32'(ph);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    // R1 reset state
    rd(12'h0, st(0), "R1 status after reset");
    rd(12'h4, 32'h0, "R1 control after reset");
    chk("R1 cfg_rst_n_o", {31'b0, rstpin}, 32'h1);
    chk("R1 chip_en_n_o", {31'b0, cen_n}, 32'h0);

    // R2 writable mask; enable clear keeps power-off (R8)
    wr(12'h4, 32'hFFFF_FFFE);
    rd(12'h4, 32'h0000_03C6, "R2 control mask");
    chk("R9 pin stays high without enable", {31'b0, rstpin}, 32'h1);
    chk("R9 field outputs", {27'b0, cen_n, ratio, dpen, wide}, 32'h1F);
    rd(12'h0, st(0), "R8 pull without enable stays off");

    // R4 enable plus pull -> reset; raise done early for R6
    cdone = 1;
    wr(12'h4, 32'h0000_0285);
    rd(12'h0, st(1), "R4 reset phase");
    chk("R9 pin low in reset", {31'b0, rstpin}, 32'h0);
    rd(12'h850, 32'h0000_0400, "R10 done mirror high");

    // R5 release pull, with data path enabled
    wr(12'h4, 32'h0000_0381);
    rd(12'h0, st(2), "R5 configuration phase");
    idle(4);
    rd(12'h0, st(2), "R6 held level does not advance");

    // R6 rising edge
    cdone = 0;
    idle(2);
    rd(12'h850, 32'h0, "R10 done mirror low");
    cdone = 1;
    idle(2);
    rd(12'h0, st(3), "R6 initialization on rise");

    // R7 exit conditions
    bdone = 1;
    idle(3);
    rd(12'h0, st(3), "R7 data path still enabled");
    bdone = 0;
    wr(12'h4, 32'h0000_0281);
    rd(12'h0, st(3), "R7 burst not done");
    bdone = 1;
    idle(2);
    rd(12'h0, st(4), "R7 user phase");

    // R8 user held with enable clear
    wr(12'h4, 32'h0);
    rd(12'h0, st(4), "R8 user held");

    // R4 from user, then R8 from configuration
    wr(12'h4, 32'h5);
    rd(12'h0, st(1), "R4 reset from user");
    wr(12'h4, 32'h1);
    rd(12'h0, st(2), "R5 configuration again");
    wr(12'h4, 32'h0);
    rd(12'h0, st(0), "R8 forced power-off");

    // R3 mode sampling
    mode = 5'h15;
    idle(2);
    rd(12'h0, st(0), "R3 new mode select");

    // R11 ignored writes and unmapped reads
    wr(12'h4, 32'h0000_0042);
    wr(12'h0, 32'hFFFF_FFFF);
    wr(12'h8, 32'hFFFF_FFFF);
    rd(12'h4, 32'h0000_0042, "R11 control untouched");
    rd(12'h0, st(0), "R11 status untouched");
    rd(12'h10, 32'h0, "R11 unmapped read");

    finished = 1;
    idle(1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule